// File: doc/BRIEF.md
# Transmit Frame Builder for 2.4 GHz Low-Rate PHY

This block assembles the byte stream of one transmit frame for a low-rate 2.4 GHz personal-area radio. After one start pulse it sends a fixed header: a run of preamble bytes, a delimiter byte and a length byte. It then sends the payload and ends with a 16-bit frame check sequence that it computes as the payload goes out. The radio back end takes the bytes over a valid/ready output. Whenever `out_ready` is low, the current byte and its valid flag are held.

The payload comes from one of two sources, picked at the start pulse. In packet mode the host has already filled a local buffer. The block reads that buffer through a combinational address/data port and raises one interrupt pulse when the frame is finished. In streaming mode the payload arrives one byte-word at a time over a valid/ready input. An interrupt pulse asks for each word and one more marks completion. The rules for a streaming source:
- Once it raises `in_valid`, it must hold `in_valid` and `in_data` until `in_ready` is high.
- `in_ready` follows `out_ready`, so back-pressure passes straight through.
- If no word is offered for `STALL_LIM` consecutive cycles during the payload, the frame is aborted and an underrun flag is set.

Top module: `pkt_framer_tx`

## Requirements
- R1: A frame begins with `PRE_BYTES` (default 4) bytes of 0x00, then the delimiter byte `SFD` (default 0xA7), then one length byte equal to the payload length plus 2.
- R2: In packet mode, payload byte k is the value of `buf_data` while `buf_addr` equals k, and the bytes are sent in order k = 0, 1, … length−1.
- R3: After the last payload byte come two check bytes, low byte first. The check value is a CRC-16 with polynomial x^16+x^12+x^5+1, initial value 0, and each byte fed least significant bit first (reflected constant 0x8408). The 9 ASCII bytes "123456789" give 0x2189.
- R4: A start with `pay_len` above `MAX_LEN` (default 125) sends nothing and leaves `busy` low. It sets `len_err`, which stays set until the next accepted start.
- R5: In packet mode, exactly one `irq` pulse is produced per frame. It is high in the cycle after the final check byte is accepted.
- R6: In streaming mode, `irq` pulses once for each payload word requested: once after the length byte, and once after every non-final word. One further pulse marks completion, so a frame gives length+1 pulses in total.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change in the next cycle.
- R8: In streaming mode, `STALL_LIM` (default 16) consecutive payload cycles without `in_valid` end the frame. No further bytes are sent, `busy` drops and `underrun` is set until the next accepted start. No completion `irq` is raised.
- R9: A `start` pulse while `busy` is high is ignored, and the running frame is unchanged.
- R10: After reset, `busy`, `out_valid`, `in_ready`, `irq`, `underrun` and `len_err` are all low.
- R11: A zero-length frame is the header with length byte 0x02, followed by check bytes 0x00 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one frame (sampled only when idle) |
| stream_mode | input | 1 | 1 = streaming source, 0 = buffer source; latched at start |
| pay_len | input | 8 | Payload length in bytes; latched at start |
| buf_addr | output | 8 | Buffer read address (payload index) |
| buf_data | input | 8 | Buffer read data, combinational from `buf_addr` |
| in_data | input | 8 | Streaming payload word |
| in_valid | input | 1 | Streaming word offered |
| in_ready | output | 1 | Streaming word taken this cycle when `in_valid` is high |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | Frame byte offered |
| out_ready | input | 1 | Downstream takes the byte |
| irq | output | 1 | Interrupt pulse (word request or frame done) |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | Last streaming frame aborted for lack of data |
| len_err | output | 1 | Last start rejected for length |

## Verification
Every payload length from 0 to 125 is sent in both modes. The length sweep catches off-by-one errors in the length byte, the last-byte detection and the empty-payload path. The two modes check that the buffer path and the handshake path feed the same header and check logic. The downstream ready signal follows a rotating pattern that stalls on different byte types, and the streaming source leaves idle gaps shorter than the stall limit. Together these separate correct hold and back-pressure behaviour from dropped or repeated bytes. Directed frames cover:
- the known check value,
- lengths just above the limit,
- a start pulse in the middle of a frame,
- a source that stops partway through.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_SFD,
    S_LEN,
    S_PAY,
    S_FCS_LO,
    S_FCS_HI
  } pf_state_e;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
endpackage

// File: rtl/pf_crc16.sv
module pf_crc16 #(
  parameter logic [15:0] POLY = 16'h8408
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_nxt;

  always_comb begin
    logic fb;
    crc_nxt = crc_q;
    for (int b = 0; b < 8; b++) begin
      fb      = crc_nxt[0] ^ din[b];
      crc_nxt = crc_nxt >> 1;
      if (fb) crc_nxt = crc_nxt ^ POLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc_nxt;
  end

  assign crc = crc_q;
endmodule

// File: rtl/pf_stall_timer.sv
module pf_stall_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!count_en) cnt <= '0;
    else if (!expired)  cnt <= cnt + 1'b1;
  end

  assign expired = count_en && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/pkt_framer_tx.sv
module pkt_framer_tx
  import pf_pkg::*;
#(
  parameter int          MAX_LEN   = 125,
  parameter int          PRE_BYTES = 4,
  parameter logic [7:0]  SFD       = 8'hA7,
  parameter int          STALL_LIM = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stream_mode,
  input  logic [7:0] pay_len,
  output logic [7:0] buf_addr,
  input  logic [7:0] buf_data,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       irq,
  output logic       busy,
  output logic       underrun,
  output logic       len_err
);
  localparam int PC_W = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;

  pf_state_e   state;
  logic [PC_W-1:0] pre_cnt;
  logic [7:0]  idx, len_q;
  logic        strm_q;
  logic [15:0] crc;
  logic        fire, last_pay, stalled, irq_evt, accept_start, abort;

  assign last_pay     = (idx == len_q - 8'd1);
  assign accept_start = (state == S_IDLE) && start && (pay_len <= 8'(MAX_LEN));
  assign abort        = (state == S_PAY) && strm_q && stalled;

  always_comb begin
    out_valid = 1'b0;
    out_data  = 8'h00;
    unique case (state)
      S_PRE:    out_valid = 1'b1;
      S_SFD:    begin out_valid = 1'b1; out_data = SFD; end
      S_LEN:    begin out_valid = 1'b1; out_data = len_q + 8'd2; end
      S_PAY:    begin
                  out_valid = strm_q ? in_valid : 1'b1;
                  out_data  = strm_q ? in_data : buf_data;
                end
      S_FCS_LO: begin out_valid = 1'b1; out_data = crc[7:0]; end
      S_FCS_HI: begin out_valid = 1'b1; out_data = crc[15:8]; end
      default:  ;
    endcase
  end

  assign fire     = out_valid && out_ready;
  assign in_ready = (state == S_PAY) && strm_q && out_ready;
  assign buf_addr = idx;
  assign busy     = (state != S_IDLE);

  assign irq_evt = fire && ( (state == S_FCS_HI)
                           || (strm_q && state == S_LEN && len_q != 8'd0)
                           || (strm_q && state == S_PAY && !last_pay) );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pre_cnt  <= '0;
      idx      <= '0;
      len_q    <= '0;
      strm_q   <= 1'b0;
      irq      <= 1'b0;
      underrun <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      irq <= irq_evt;
      if (state == S_IDLE) begin
        if (start) len_err <= (pay_len > 8'(MAX_LEN));
        if (accept_start) begin
          state    <= S_PRE;
          pre_cnt  <= '0;
          idx      <= '0;
          len_q    <= pay_len;
          strm_q   <= stream_mode;
          underrun <= 1'b0;
        end
      end else if (abort) begin
        state    <= S_IDLE;
        underrun <= 1'b1;
      end else if (fire) begin
        unique case (state)
          S_PRE: begin
            pre_cnt <= pre_cnt + 1'b1;
            if (pre_cnt == PC_W'(PRE_BYTES - 1)) state <= S_SFD;
          end
          S_SFD:    state <= S_LEN;
          S_LEN:    state <= (len_q == 8'd0) ? S_FCS_LO : S_PAY;
          S_PAY: begin
            idx <= idx + 8'd1;
            if (last_pay) state <= S_FCS_LO;
          end
          S_FCS_LO: state <= S_FCS_HI;
          S_FCS_HI: state <= S_IDLE;
          default:  state <= S_IDLE;
        endcase
      end
    end
  end

  pf_crc16 #(.POLY(CRC_POLY_REFL)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept_start),
    .en    (fire && state == S_PAY),
    .din   (out_data),
    .crc   (crc)
  );

  pf_stall_timer #(.LIMIT(STALL_LIM)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en ((state == S_PAY) && strm_q && !in_valid),
    .expired  (stalled)
  );
endmodule

// File: rtl/pf_framer_chk.sv
module pf_framer_chk #(
  parameter int MAX_LEN = 125
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       in_ready,
  input logic       busy,
  input logic       underrun,
  input logic       len_err,
  input logic [7:0] buf_addr
);
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !in_ready); // R10

  AST_LEN_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !busy); // R4

  AST_UNDERRUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> !busy); // R8

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> buf_addr <= 8'(MAX_LEN)); // R2
endmodule

bind pkt_framer_tx pf_framer_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .in_ready  (in_ready),
  .busy      (busy),
  .underrun  (underrun),
  .len_err   (len_err),
  .buf_addr  (buf_addr)
);

// File: tb/pkt_framer_tx_bench.sv
module pkt_framer_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXL  = 125;
  localparam int STALL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stream_mode = 1'b0;
  logic [7:0] pay_len = '0;
  logic [7:0] buf_addr, buf_data;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_ready;
  logic [7:0] out_data;
  logic       out_valid, out_ready = 1'b0;
  logic       irq, busy, underrun, len_err;

  logic [7:0] mem [0:255];
  logic [7:0] got [0:511];
  logic [7:0] expb [0:511];
  int n_got, n_irq;
  int checks = 0, failures = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign buf_data = mem[buf_addr];

  pkt_framer_tx #(.MAX_LEN(MAXL), .STALL_LIM(STALL)) u_pkt_framer_tx (
    .clk(clk), .rst_n(rst_n), .start(start), .stream_mode(stream_mode),
    .pay_len(pay_len), .buf_addr(buf_addr), .buf_data(buf_data),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .irq(irq), .busy(busy), .underrun(underrun), .len_err(len_err));

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  function automatic logic [15:0] crc_ref(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic f;
        f = c[0] ^ mem[i][b];
        c = c >> 1;
        if (f) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  // Run one frame; stop_at limits how many stream words the source offers.
  task automatic run_frame(input int len, input bit strm, input int stop_at,
                           input int inject_at, output bit hold_bad);
    int src_idx = 0, gap = 0, it = 0;
    bit src_v = 0, prev_stall = 0;
    logic [7:0] prev_d = '0;
    hold_bad = 0; n_got = 0; n_irq = 0;
    @(negedge clk);
    start = 1; pay_len = 8'(len); stream_mode = strm;
    @(negedge clk);
    start = 0;
    for (it = 0; it < 4000; it++) begin
      out_ready = ((it * 7 + len) % 5) != 0;
      if (!src_v && gap == 0 && src_idx < stop_at) src_v = 1;
      else if (gap > 0) gap--;
      in_valid = strm && src_v;
      in_data  = mem[src_idx];
      if (it == inject_at) begin start = 1; pay_len = 8'd3; end
      else start = 0;
      #1;
      if (irq) n_irq++;
      if (!busy) break;
      if (prev_stall && (!out_valid || out_data != prev_d)) hold_bad = 1;
      prev_stall = out_valid && !out_ready;
      prev_d = out_data;
      if (out_valid && out_ready) begin got[n_got] = out_data; n_got++; end
      if (in_valid && in_ready) begin src_idx++; src_v = 0; gap = src_idx % 3; end
      @(negedge clk);
    end
    in_valid = 0; start = 0; out_ready = 0;
  endtask

  function automatic int build_exp(input int len);
    int n = 0;
    logic [15:0] c = crc_ref(len);
    for (int i = 0; i < 4; i++) begin expb[n] = 8'h00; n++; end
    expb[n] = 8'hA7; n++;
    expb[n] = 8'(len + 2); n++;
    for (int i = 0; i < len; i++) begin expb[n] = mem[i]; n++; end
    expb[n] = c[7:0]; n++;
    expb[n] = c[15:8]; n++;
    return n;
  endfunction

  task automatic cmp_frame(input string tag, input int len);
    int n = build_exp(len);
    int bad = -1;
    if (n_got != n) bad = n;
    else for (int i = 0; i < n; i++) if (bad < 0 && got[i] != expb[i]) bad = i;
    chk(bad < 0, tag, (bad >= 0 && bad < n_got) ? int'(got[bad]) : n_got,
        (bad >= 0 && bad < n) ? int'(expb[bad]) : n);
  endtask

  initial begin
    bit hb;
    // R10 reset state
    #(CLK_PERIOD * 3);
    chk(!busy && !out_valid && !in_ready && !irq && !underrun && !len_err,
        "R10 reset outputs", {busy, out_valid, in_ready, irq, underrun, len_err}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R5 R7 R11: packet-mode sweep over every length
    for (int len = 0; len <= MAXL; len++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + len * 11) & 8'hFF);
      run_frame(len, 1'b0, 0, -1, hb);
      cmp_frame(len == 0 ? "R11 empty packet frame" : "R1_R2_R3 packet frame", len);
      chk(n_irq == 1, "R5 packet irq count", n_irq, 1);
      chk(!hb, "R7 hold under stall", hb, 0);
    end

    // R6 R1 R3 R7: streaming sweep over every length
    for (int len = 0; len <= MAXL; len++) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 91 + len * 5 + 3) & 8'hFF);
      run_frame(len, 1'b1, len, -1, hb);
      cmp_frame(len == 0 ? "R11 empty stream frame" : "R1_R3 stream frame", len);
      chk(n_irq == len + 1, "R6 stream irq count", n_irq, len + 1);
      chk(!hb, "R7 hold under stall stream", hb, 0);
    end

    // R3 known check value
    begin
      string s = "123456789";
      for (int i = 0; i < 9; i++) mem[i] = s[i];
      run_frame(9, 1'b1, 9, -1, hb);
      chk(n_got == 17 && got[15] == 8'h89 && got[16] == 8'h21, "R3 check value",
          {got[16], got[15]}, 16'h2189);
    end

    // R9 start while busy is ignored
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    run_frame(20, 1'b0, 0, 8, hb);
    cmp_frame("R9 frame unchanged by start", 20);
    repeat (3) @(negedge clk);
    chk(!busy && !out_valid, "R9 no second frame", busy, 0);

    // R4 length above limit rejected
    for (int l = MAXL + 1; l <= MAXL + 3; l++) begin
      @(negedge clk); start = 1; pay_len = 8'(l); stream_mode = 0;
      @(negedge clk); start = 0;
      repeat (3) begin
        #1;
        chk(!busy && !out_valid && len_err, "R4 reject long", {busy, out_valid, len_err}, 1);
        @(negedge clk);
      end
    end
    run_frame(2, 1'b0, 0, -1, hb);
    chk(!len_err, "R4 len_err cleared", len_err, 0);
    cmp_frame("R4 valid frame after reject", 2);

    // R8 underrun: source stops after 3 words of 10
    for (int i = 0; i < 256; i++) mem[i] = 8'(i + 1);
    run_frame(10, 1'b1, 3, -1, hb);
    chk(n_got == 9, "R8 bytes before abort", n_got, 9);
    chk(underrun && !busy, "R8 underrun set", {underrun, busy}, 2);
    chk(n_irq == 4, "R8 no done irq", n_irq, 4);
    repeat (3) @(negedge clk);
    chk(!out_valid && underrun, "R8 stays stopped", {out_valid, underrun}, 1);
    run_frame(1, 1'b1, 1, -1, hb);
    chk(!underrun, "R8 underrun cleared by start", underrun, 0);
    cmp_frame("R8 frame after underrun", 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule